// File: doc/BRIEF.md
# Greedy Sequential Lock Arbiter

This block lets N requesters share one upstream lock. Each requester and the upstream lock use a four-phase req/ack handshake. While no requester is asking, the block stays quiet. When at least one requester raises its request, the block asks for the upstream lock once. Under that single grant it serves every ready requester in turn, in ascending index order. It then releases the lock and waits for the upstream grant to fall before it can start another pass.

The block is a clocked Moore state machine with five states. ST_IDLE waits for any request while the grant is low. ST_LOCK_WAIT holds the lock request high until the grant arrives, and then clears the index to 0. ST_VISIT samples the request of the current index: a requesting child moves the machine to ST_ACK, an idle child advances the index, and an idle last child moves it to ST_RELEASE. ST_ACK holds that child's ack high until its request falls, then advances the index, or goes to ST_RELEASE after the last child. ST_RELEASE drops the lock request and returns to ST_IDLE once the grant is low.

A request is sampled at the clock edge on which its index is visited. A request that rises after its turn has passed waits for the next pass.

Top module: `seq_lock_arbiter`

## Requirements
- R1: While no child request is high, the lock request stays low and no pass starts.
- R2: A child ack is high only while both the lock request and the lock grant are high.
- R3: Within one pass, children are acknowledged in ascending index order, whatever order their requests rose in.
- R4: A child ack rises only when that child is requesting, and falls only after that child's request is low. No other child is acknowledged until that ack has fallen.
- R5: A child whose request is low when its index is visited gets no ack activity in that pass.
- R6: The lock request falls only after every acknowledged child has finished its handshake, so it never falls while an ack is high.
- R7: The lock request never rises while the lock grant is still high from the previous tenure.
- R8: At most one child ack is high at a time, and each child is acknowledged at most once per pass. A child that re-asserts its request right away is served only after the higher-index requesters.
- R9: A request that rises after its index has been visited is served in the next pass.
- R10: While reset is low, every child ack and the lock request are low, and after reset the block is in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| child_req | input | N | Per-child request; bit i belongs to child i |
| child_ack | output | N | Per-child acknowledge, at most one high |
| lock_req | output | 1 | Upstream lock request |
| lock_gnt | input | 1 | Upstream lock grant |

## Verification
The checker watches every cycle for the handshake properties:
- mutually exclusive acks;
- acks only under a held lock;
- ack edges that follow the owning child's request;
- lock request edges that respect idle requesters and a still-high grant.

Service order, skipping of idle children, deferral of late requests to the next pass, and fairness against a child that re-asserts at once all depend on a sequence of acks across a pass. Only the directed scenarios can show these, by logging the order of ack rises and the number of lock tenures.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOCK_WAIT,
        ST_VISIT,
        ST_ACK,
        ST_RELEASE
    } sla_state_e;
endpackage

// File: rtl/sla_index_ctr.sv
module sla_index_ctr #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [IW-1:0] idx,
    output logic          last
);
    localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx <= '0;
        end else if (adv && idx != LAST_IDX) begin
            idx <= idx + 1'b1;
        end
    end

    assign last = (idx == LAST_IDX);
endmodule

// File: rtl/sla_req_pick.sv
module sla_req_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] idx,
    output logic          sel_req,
    output logic          any_req
);
    assign sel_req = req[idx];
    assign any_req = |req;
endmodule

// File: rtl/sla_ack_dec.sv
module sla_ack_dec #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          en,
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  ack
);
    for (genvar g = 0; g < N; g++) begin : g_dec
        assign ack[g] = en && (idx == IW'(g));
    end
endmodule

// File: rtl/seq_lock_arbiter.sv
module seq_lock_arbiter
    import seq_lock_pkg::*;
#(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] child_req,
    output logic [N-1:0] child_ack,
    output logic         lock_req,
    input  logic         lock_gnt
);
    sla_state_e state, state_nx;
    logic [IW-1:0] idx;
    logic          last, sel_req, any_req;
    logic          ctr_clr, ctr_adv, ack_en;

    sla_index_ctr #(.N(N)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clr(ctr_clr), .adv(ctr_adv),
        .idx(idx), .last(last)
    );

    sla_req_pick #(.N(N)) u_pick (
        .req(child_req), .idx(idx), .sel_req(sel_req), .any_req(any_req)
    );

    sla_ack_dec #(.N(N)) u_dec (
        .en(ack_en), .idx(idx), .ack(child_ack)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (any_req && !lock_gnt) state_nx = ST_LOCK_WAIT;
            ST_LOCK_WAIT: if (lock_gnt)             state_nx = ST_VISIT;
            ST_VISIT: begin
                if (sel_req)   state_nx = ST_ACK;
                else if (last) state_nx = ST_RELEASE;
            end
            ST_ACK: begin
                if (!sel_req && last) state_nx = ST_RELEASE;
                else if (!sel_req)    state_nx = ST_VISIT;
            end
            ST_RELEASE:   if (!lock_gnt)            state_nx = ST_IDLE;
            default:                                state_nx = ST_IDLE;
        endcase
    end

    // Outputs and index control
    always_comb begin
        lock_req = 1'b0;
        ack_en   = 1'b0;
        ctr_clr  = 1'b0;
        ctr_adv  = 1'b0;
        unique case (state)
            ST_IDLE:      ;
            ST_LOCK_WAIT: begin lock_req = 1'b1; ctr_clr = 1'b1; end
            ST_VISIT:     begin lock_req = 1'b1; ctr_adv = !sel_req; end
            ST_ACK:       begin lock_req = 1'b1; ack_en = 1'b1; ctr_adv = !sel_req; end
            ST_RELEASE:   ;
            default:      ;
        endcase
    end
endmodule

// File: rtl/sla_checker.sv
module sla_checker #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] child_req,
    input logic [N-1:0] child_ack,
    input logic         lock_req,
    input logic         lock_gnt
);
    assert_idle_no_lock_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_req) |-> $past(|child_req));

    assert_ack_under_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|child_ack) |-> (lock_req && lock_gnt));

    assert_release_after_handshake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_req) |-> (child_ack == '0));

    assert_no_reacquire_while_granted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_req) |-> !$past(lock_gnt));

    assert_ack_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(child_ack));

    for (genvar g = 0; g < N; g++) begin : g_child
        assert_ack_rise_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(child_ack[g]) |-> $past(child_req[g]));

        assert_ack_fall_after_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(child_ack[g]) |-> !$past(child_req[g]));
    end
endmodule

bind seq_lock_arbiter sla_checker #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .child_req(child_req), .child_ack(child_ack),
    .lock_req(lock_req), .lock_gnt(lock_gnt)
);

// File: tb/sim_seq_lock_arbiter.sv
`timescale 1ns/1ps
module sim_seq_lock_arbiter;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] child_req = '0;
    logic [N-1:0] child_ack;
    logic         lock_req;
    logic         lock_gnt = 1'b0;

    seq_lock_arbiter #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .child_req(child_req), .child_ack(child_ack),
        .lock_req(lock_req), .lock_gnt(lock_gnt)
    );

    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    // Upstream lock model
    int gnt_lat = 2;
    int rel_lat = 2;
    int up_cnt  = 0;

    // Child models and monitors
    int drop_dly [N];
    int hold_cnt [N];
    bit rearm    [N];
    int ack_log  [64];
    int n_log = 0;
    int lock_rises = 0;
    int ack2_high = 0;
    int v_onehot = 0, v_gnt = 0, v_early = 0, v_regrab = 0, v_release = 0;
    logic [N-1:0] prev_ack = '0;
    logic prev_lock = 1'b0;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (lock_req && !lock_gnt) begin
            up_cnt++;
            if (up_cnt >= gnt_lat) begin lock_gnt = 1'b1; up_cnt = 0; end
        end else if (!lock_req && lock_gnt) begin
            up_cnt++;
            if (up_cnt >= rel_lat) begin lock_gnt = 1'b0; up_cnt = 0; end
        end else begin
            up_cnt = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if ($countones(child_ack) > 1) v_onehot++;
            if ((|child_ack) && !(lock_gnt && lock_req)) v_gnt++;
            if (lock_req && !prev_lock && lock_gnt) v_regrab++;
            if (!lock_req && prev_lock && (|child_ack)) v_release++;
            if (lock_req && !prev_lock) lock_rises++;
            if (child_ack[2]) ack2_high++;
            for (int i = 0; i < N; i++) begin
                if (child_ack[i] && !prev_ack[i] && n_log < 64) begin
                    ack_log[n_log] = i; n_log++;
                end
                if (prev_ack[i] && !child_ack[i]) begin
                    if (child_req[i]) v_early++;
                    if (rearm[i]) begin child_req[i] = 1'b1; rearm[i] = 1'b0; end
                end
                if (child_ack[i] && child_req[i]) begin
                    hold_cnt[i]++;
                    if (hold_cnt[i] >= drop_dly[i]) child_req[i] = 1'b0;
                end else begin
                    hold_cnt[i] = 0;
                end
            end
        end
        prev_ack  = child_ack;
        prev_lock = lock_req;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        n_log = 0; lock_rises = 0; ack2_high = 0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        for (int k = 0; k < 2000 && q < 4; k++) begin
            @(negedge clk);
            if (!lock_req && !lock_gnt && child_req == '0 && child_ack == '0) q++;
            else q = 0;
        end
    endtask

    task automatic chk_log(input string tag, input int exp_q[$]);
        chk(n_log == exp_q.size(), tag, n_log, exp_q.size());
        for (int k = 0; k < exp_q.size() && k < n_log; k++)
            chk(ack_log[k] == exp_q[k], tag, ack_log[k], exp_q[k]);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(child_ack == '0, "R10 acks low in reset", int'(child_ack), 0);
        chk(lock_req == 1'b0, "R10 lock_req low in reset", int'(lock_req), 0);
        rst_n = 1'b1;
        clear_logs();
        repeat (20) @(negedge clk);
        chk(lock_rises == 0, "R1 no lock while idle", lock_rises, 0);
        chk(lock_req == 1'b0, "R1 lock_req stays low", int'(lock_req), 0);
    endtask

    task automatic t_single();
        clear_logs();
        child_req[2] = 1'b1;
        wait_quiet();
        chk_log("R5 only child 2 served", '{2});
        chk(lock_rises == 1, "R5 one tenure", lock_rises, 1);
    endtask

    task automatic t_order();
        clear_logs();
        gnt_lat = 8;
        child_req[3] = 1'b1; @(negedge clk); @(negedge clk);
        child_req[1] = 1'b1; @(negedge clk);
        child_req[0] = 1'b1; child_req[2] = 1'b1;
        wait_quiet();
        gnt_lat = 2;
        chk_log("R3 ascending order", '{0, 1, 2, 3});
        chk(lock_rises == 1, "R3 single tenure for all", lock_rises, 1);
    endtask

    task automatic t_fair();
        clear_logs();
        gnt_lat = 4;
        rearm[0] = 1'b1;
        child_req[0] = 1'b1; child_req[3] = 1'b1;
        wait_quiet();
        chk_log("R8 re-asserter waits", '{0, 3, 0});
        chk(lock_rises == 2, "R8 two tenures", lock_rises, 2);
        gnt_lat = 2;
    endtask

    task automatic t_late();
        clear_logs();
        rel_lat = 6;
        child_req[1] = 1'b1;
        for (int k = 0; k < 200 && !child_ack[1]; k++) @(negedge clk);
        child_req[0] = 1'b1;
        wait_quiet();
        chk_log("R9 late request next pass", '{1, 0});
        chk(lock_rises == 2, "R9 second tenure", lock_rises, 2);
        chk(v_regrab == 0, "R7 no reacquire under grant", v_regrab, 0);
        rel_lat = 2;
    endtask

    task automatic t_hold();
        clear_logs();
        drop_dly[2] = 10;
        child_req[2] = 1'b1; child_req[3] = 1'b1;
        wait_quiet();
        drop_dly[2] = 2;
        chk_log("R4 hold then next child", '{2, 3});
        chk(ack2_high >= 10, "R4 ack held until req falls", ack2_high, 10);
        chk(v_early == 0, "R4 ack never falls before req", v_early, 0);
        chk(v_onehot == 0, "R8 acks mutually exclusive", v_onehot, 0);
        chk(v_gnt == 0, "R2 ack only under grant", v_gnt, 0);
        chk(v_release == 0, "R6 lock held through handshakes", v_release, 0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin drop_dly[i] = 2; hold_cnt[i] = 0; rearm[i] = 1'b0; end
        t_reset();
        t_single();
        t_order();
        t_fair();
        t_late();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule